// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations so that a load or store path can turn a virtual address into a physical one in the same cycle it is presented. Every entry can hold any translation. A lookup compares the virtual page number against all valid entries at once. On a hit the block returns the physical page number, with the untouched page offset appended, as the physical address.

A demand lookup that misses raises a walk request toward a hardware page table walker. The walker's result comes back on the fill port and is installed. A prefetch lookup that misses is dropped: it starts no walk and only reports a drop flag. Entry writes, fills and invalidations take effect only while the kernel-mode input is high. Victims are chosen by a one-reference-bit approximation of least-recently-used.

Top module: `fa_tlb`

## Requirements
- R1: A lookup with `lk_valid` high hits when the virtual page number (address bits above the page offset) equals the tag of any valid entry. In that same cycle `hit` is 1 and `pa` is the entry's page number concatenated with the lookup's page offset. `pa` is 0 when there is no hit.
- R2: A demand lookup (`lk_prefetch` = 0) that misses drives `walk_req` high and `walk_vpn` to the lookup page number in the same cycle, with `miss_drop` low.
- R3: A prefetch lookup (`lk_prefetch` = 1) that misses drives `miss_drop` high and never `walk_req`. A prefetch lookup that hits returns the translation like a demand lookup.
- R4: A fill accepted in one cycle is visible to lookups from the next cycle.
- R5: A fill whose page number is not present goes to the lowest-index invalid entry. When all entries are valid, it goes to the lowest-index entry whose reference bit is clear.
- R6: An entry's reference bit is set when a lookup hits it and when it is installed. If that would leave every bit set, all bits are cleared except the newest one: the entry installed this cycle, or else the one hit.
- R7: A fill whose page number already has a valid entry overwrites that entry's page number, and no other entry changes.
- R8: While `kmode` is 0, fills, entry writes, single invalidates and global invalidates have no effect on the stored translations.
- R9: A global invalidate clears every entry in one cycle.
- R10: A single invalidate clears the valid entry whose tag equals `inv_vpn`, and only that entry.
- R11: An entry write stores the given tag, page number and valid bit into the entry at `wr_idx`.
- R12: When several update commands arrive in one cycle, only one is applied, in this priority order: global invalidate, single invalidate, entry write, fill.
- R13: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_prefetch | input | 1 | 1 = prefetch lookup, 0 = demand lookup |
| lk_vaddr | input | VA_W | Virtual address of the lookup |
| hit | output | 1 | Lookup hit |
| ppn | output | PPN_W | Page number of the hit entry |
| pa | output | PPN_W+OFF_W | Physical address of the hit |
| walk_req | output | 1 | Demand miss, request a page walk |
| walk_vpn | output | VA_W-OFF_W | Page number to walk |
| miss_drop | output | 1 | Prefetch miss dropped |
| kmode | input | 1 | Kernel mode, enables all updates |
| fill_valid | input | 1 | Completed walk present |
| fill_vpn | input | VA_W-OFF_W | Page number of the walk result |
| fill_ppn | input | PPN_W | Physical page number of the walk result |
| wr_en | input | 1 | Explicit entry write |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | VA_W-OFF_W | Tag to write |
| wr_ppn | input | PPN_W | Page number to write |
| wr_vld | input | 1 | Valid bit to write |
| inv_one | input | 1 | Invalidate the entry matching `inv_vpn` |
| inv_vpn | input | VA_W-OFF_W | Page number to invalidate |
| inv_all | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with four entries instead of the default eight, keeping the other widths at their defaults. With four entries a handful of fills fills the buffer, so victim choice among clear reference bits, the all-set wipe, and eviction of a recently installed entry are all reached within a few dozen cycles. The sequence is chosen so that the victim order under the reference-bit wipe differs from plain lowest-index or round-robin order.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;

    typedef enum logic [2:0] {
        UPD_NONE,
        UPD_INV_ALL,
        UPD_INV_ONE,
        UPD_WRITE,
        UPD_FILL
    } upd_kind_e;

endpackage

// File: rtl/fa_tlb_match.sv
module fa_tlb_match #(
    parameter int N     = 8,
    parameter int VPN_W = 20
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            match
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

endmodule

// File: rtl/fa_tlb_enc.sv
module fa_tlb_enc #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     oh,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (oh[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/fa_tlb_victim.sv
module fa_tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     refb,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] cold_idx;

    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
            if (!refb[i])  cold_idx = IDX_W'(i);
        end
        if (|(~valid))     idx = free_idx;
        else if (|(~refb)) idx = cold_idx;
        else               idx = '0;
    end

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
    import fa_tlb_pkg::*;
#(
    parameter int N     = 8,
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PPN_W = 18,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_prefetch,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             hit,
    output logic [PPN_W-1:0] ppn,
    output logic [PA_W-1:0]  pa,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    output logic             miss_drop,
    input  logic             kmode,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_vld,
    input  logic             inv_one,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             inv_all
);

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0]            refb;
        logic [N-1:0][VPN_W-1:0] tag;
        logic [N-1:0][PPN_W-1:0] pfn;
    } state_t;

    state_t s_q, s_d;

    logic [VPN_W-1:0] lk_vpn;
    logic [OFF_W-1:0] lk_off;
    logic [N-1:0]     lk_vec, fill_vec, inv_vec;
    logic [IDX_W-1:0] lk_idx, fill_idx, victim_idx;
    logic             lk_any;
    upd_kind_e        upd_kind;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    fa_tlb_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
        .valid (s_q.valid), .tags (s_q.tag), .key (lk_vpn), .match (lk_vec)
    );
    fa_tlb_match #(.N(N), .VPN_W(VPN_W)) u_fill_match (
        .valid (s_q.valid), .tags (s_q.tag), .key (fill_vpn), .match (fill_vec)
    );
    fa_tlb_match #(.N(N), .VPN_W(VPN_W)) u_inv_match (
        .valid (s_q.valid), .tags (s_q.tag), .key (inv_vpn), .match (inv_vec)
    );
    fa_tlb_enc #(.N(N), .IDX_W(IDX_W)) u_lk_enc (.oh (lk_vec), .idx (lk_idx));
    fa_tlb_enc #(.N(N), .IDX_W(IDX_W)) u_fill_enc (.oh (fill_vec), .idx (fill_idx));
    fa_tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .valid (s_q.valid), .refb (s_q.refb), .idx (victim_idx)
    );

    // Lookup result path: purely combinational from stored state.
    always_comb begin
        lk_any    = |lk_vec;
        hit       = lk_valid && lk_any;
        ppn       = hit ? s_q.pfn[lk_idx] : '0;
        pa        = hit ? {s_q.pfn[lk_idx], lk_off} : '0;
        walk_req  = lk_valid && !lk_any && !lk_prefetch;
        miss_drop = lk_valid && !lk_any && lk_prefetch;
        walk_vpn  = lk_vpn;
    end

    // Select the single update applied this cycle.
    always_comb begin
        upd_kind = UPD_NONE;
        if (kmode) begin
            if (inv_all)         upd_kind = UPD_INV_ALL;
            else if (inv_one)    upd_kind = UPD_INV_ONE;
            else if (wr_en)      upd_kind = UPD_WRITE;
            else if (fill_valid) upd_kind = UPD_FILL;
        end
    end

    // Next-state computation.
    always_comb begin
        logic [N-1:0]     touch_oh;
        logic [N-1:0]     inst_oh;
        logic [N-1:0]     ref_n;
        logic [IDX_W-1:0] tgt;

        s_d      = s_q;
        touch_oh = '0;
        inst_oh  = '0;
        tgt      = '0;

        if (hit) touch_oh[lk_idx] = 1'b1;

        case (upd_kind)
            UPD_INV_ALL: begin
                s_d.valid = '0;
            end
            UPD_INV_ONE: begin
                s_d.valid = s_q.valid & ~inv_vec;
            end
            UPD_WRITE: begin
                s_d.tag[wr_idx]   = wr_vpn;
                s_d.pfn[wr_idx]   = wr_ppn;
                s_d.valid[wr_idx] = wr_vld;
                if (wr_vld) inst_oh[wr_idx] = 1'b1;
            end
            UPD_FILL: begin
                tgt            = (|fill_vec) ? fill_idx : victim_idx;
                s_d.tag[tgt]   = fill_vpn;
                s_d.pfn[tgt]   = fill_ppn;
                s_d.valid[tgt] = 1'b1;
                inst_oh[tgt]   = 1'b1;
            end
            default: ;
        endcase

        ref_n = (s_q.refb | touch_oh | inst_oh) & s_d.valid;
        if (N > 1 && (&ref_n)) begin
            ref_n = (|inst_oh) ? inst_oh : touch_oh;
        end
        s_d.refb = ref_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: a walk is requested only for lookups that did not hit
    a_r2_walk_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !hit);

    // R3: prefetches never start a walk
    a_r3_prefetch_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_prefetch |-> !walk_req);

    // R5: a new page goes to a free slot whenever one exists
    a_r5_victim_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_kind == UPD_FILL && !(|fill_vec) && !(&s_q.valid)) |-> !s_q.valid[victim_idx]);

    // R6: reference bits are never all set after an update
    a_r6_ref_not_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        (N > 1) |-> !(&s_q.refb));

    // R8: outside kernel mode stored translations stay unchanged
    a_r8_user_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !kmode |=> (s_q.valid == $past(s_q.valid)) && (s_q.tag == $past(s_q.tag))
                   && (s_q.pfn == $past(s_q.pfn)));

    // R9: global invalidate empties the buffer in one cycle
    a_r9_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        (kmode && inv_all) |=> (s_q.valid == '0));

endmodule

// File: tb/fa_tlb_bench.sv
`timescale 1ns/1ps
module fa_tlb_bench;

    localparam int N     = 4;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int PPN_W = 18;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid, lk_prefetch;
    logic [VA_W-1:0]  lk_vaddr;
    logic             hit, walk_req, miss_drop;
    logic [PPN_W-1:0] ppn;
    logic [PA_W-1:0]  pa;
    logic [VPN_W-1:0] walk_vpn;
    logic             kmode, fill_valid, wr_en, wr_vld, inv_one, inv_all;
    logic [VPN_W-1:0] fill_vpn, wr_vpn, inv_vpn;
    logic [PPN_W-1:0] fill_ppn, wr_ppn;
    logic [IDX_W-1:0] wr_idx;

    always #2 clk = ~clk;

    fa_tlb #(.N(N), .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_fa_tlb (
        .clk, .rst_n, .lk_valid, .lk_prefetch, .lk_vaddr, .hit, .ppn, .pa,
        .walk_req, .walk_vpn, .miss_drop, .kmode, .fill_valid, .fill_vpn,
        .fill_ppn, .wr_en, .wr_idx, .wr_vpn, .wr_ppn, .wr_vld, .inv_one,
        .inv_vpn, .inv_all
    );

    typedef struct {
        logic             hit;
        logic             drop;
        logic             walk;
        logic [PA_W-1:0]  pa;
        logic [VPN_W-1:0] vpn;
        string            tag;
    } exp_t;

    exp_t queue_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 0;
    event sample_ev;

    task automatic idle();
        lk_valid = 0; lk_prefetch = 0; lk_vaddr = '0;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0;
        wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_ppn = '0; wr_vld = 0;
        inv_one = 0; inv_vpn = '0; inv_all = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        idle();
    endtask

    // Driver: applies a lookup and pushes the expected response.
    task automatic look(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        input logic pf, input logic exp_hit,
                        input logic [PPN_W-1:0] exp_ppn, input string tag);
        exp_t e;
        @(negedge clk);
        lk_valid = 1; lk_prefetch = pf; lk_vaddr = {vpn, off};
        e.hit  = exp_hit;
        e.drop = !exp_hit && pf;
        e.walk = !exp_hit && !pf;
        e.pa   = exp_hit ? {exp_ppn, off} : '0;
        e.vpn  = vpn;
        e.tag  = tag;
        queue_q.push_back(e);
        #1 -> sample_ev;
        step();
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] p);
        @(negedge clk);
        fill_valid = 1; fill_vpn = vpn; fill_ppn = p;
        step();
    endtask

    // Monitor: pops expected items and compares them against the outputs.
    always @(sample_ev) begin
        exp_t e;
        if (queue_q.size() == 0) begin
            n_checks++; n_fails++;
            $display("FAIL monitor: response with empty scoreboard");
        end else begin
            e = queue_q.pop_front();
            n_checks++;
            if (hit !== e.hit || miss_drop !== e.drop || walk_req !== e.walk ||
                pa !== e.pa || (e.walk && walk_vpn !== e.vpn)) begin
                n_fails++;
                $display("FAIL %s: got hit=%0b drop=%0b walk=%0b pa=%h wvpn=%h exp hit=%0b drop=%0b walk=%0b pa=%h wvpn=%h",
                         e.tag, hit, miss_drop, walk_req, pa, walk_vpn,
                         e.hit, e.drop, e.walk, e.pa, e.vpn);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle();
        kmode = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R13 / R2 / R3: empty after reset
        look(20'h00011, 12'h000, 0, 0, '0, "R13 reset empty, R2 demand miss");
        look(20'h00011, 12'h010, 1, 0, '0, "R3 prefetch miss dropped");

        // R4 / R5: fills go to free slots 0,1,2
        fill(20'h00011, 18'h00101);
        fill(20'h00022, 18'h00202);
        fill(20'h00033, 18'h00303);
        look(20'h00022, 12'hABC, 0, 1, 18'h00202, "R1 R4 hit after fill");
        look(20'h00011, 12'h123, 0, 1, 18'h00101, "R4 first fill visible");
        // fourth fill fills slot 3, references wiped to only slot 3
        fill(20'h00044, 18'h00404);
        // R5: full, lowest clear reference -> slot 0 (0x11)
        fill(20'h00055, 18'h00505);
        look(20'h00011, 12'h000, 0, 0, '0, "R5 slot0 evicted");
        look(20'h00055, 12'h777, 0, 1, 18'h00505, "R5 new page hit");
        look(20'h00022, 12'h001, 0, 1, 18'h00202, "R1 slot1 kept");
        // refs now slots 0,1,3 -> victim slot 2 (0x33); wipe leaves slot 2
        fill(20'h00066, 18'h00606);
        look(20'h00033, 12'h000, 0, 0, '0, "R6 slot2 evicted");
        look(20'h00066, 12'h002, 0, 1, 18'h00606, "R6 slot2 refilled");
        // refs only slot 2 -> victim slot 0 (0x55)
        fill(20'h00077, 18'h00707);
        look(20'h00055, 12'h000, 0, 0, '0, "R6 wipe made slot0 victim");
        look(20'h00077, 12'h003, 0, 1, 18'h00707, "R6 slot0 refilled");
        look(20'h00044, 12'h004, 0, 1, 18'h00404, "R6 slot3 hit");
        // hit on slot1 saturates refs -> only slot1 survives
        look(20'h00022, 12'h005, 0, 1, 18'h00202, "R6 saturating hit");
        fill(20'h00088, 18'h00808);
        look(20'h00077, 12'h000, 0, 0, '0, "R6 hit-wipe made slot0 victim");
        look(20'h00088, 12'h006, 0, 1, 18'h00808, "R6 slot0 new page");

        // R7: duplicate fill overwrites in place
        fill(20'h00066, 18'h006AA);
        look(20'h00066, 12'h007, 0, 1, 18'h006AA, "R7 overwrite");
        look(20'h00088, 12'h008, 0, 1, 18'h00808, "R7 no eviction slot0");
        look(20'h00022, 12'h009, 0, 1, 18'h00202, "R7 no eviction slot1");
        look(20'h00044, 12'h00A, 0, 1, 18'h00404, "R7 no eviction slot3");

        // R8: user mode ignores every update
        kmode = 0;
        fill(20'h00099, 18'h00909);
        @(negedge clk); inv_all = 1; step();
        @(negedge clk); wr_en = 1; wr_idx = 2'd1; wr_vpn = 20'h000AA; wr_ppn = 18'h00A0A; wr_vld = 1; step();
        @(negedge clk); inv_one = 1; inv_vpn = 20'h00044; step();
        look(20'h00099, 12'h000, 0, 0, '0, "R8 fill ignored");
        look(20'h000AA, 12'h000, 0, 0, '0, "R8 write ignored");
        look(20'h00022, 12'h00B, 0, 1, 18'h00202, "R8 flush and write ignored");
        look(20'h00044, 12'h00C, 0, 1, 18'h00404, "R8 single invalidate ignored");
        kmode = 1;

        // R11: explicit write to slot 2
        @(negedge clk); wr_en = 1; wr_idx = 2'd2; wr_vpn = 20'h000BB; wr_ppn = 18'h00B0B; wr_vld = 1; step();
        look(20'h000BB, 12'hFFF, 0, 1, 18'h00B0B, "R11 written entry hits");
        look(20'h00066, 12'h000, 0, 0, '0, "R11 old tag gone");

        // R10: single invalidate
        @(negedge clk); inv_one = 1; inv_vpn = 20'h00022; step();
        look(20'h00022, 12'h000, 0, 0, '0, "R10 entry invalidated");
        look(20'h00088, 12'h00D, 0, 1, 18'h00808, "R10 other entry kept");

        // R12: single invalidate beats fill
        @(negedge clk); inv_one = 1; inv_vpn = 20'h00088;
        fill_valid = 1; fill_vpn = 20'h000CC; fill_ppn = 18'h00C0C; step();
        look(20'h00088, 12'h000, 0, 0, '0, "R12 invalidate applied");
        look(20'h000CC, 12'h000, 0, 0, '0, "R12 fill dropped");
        // R12: write beats fill
        @(negedge clk); wr_en = 1; wr_idx = 2'd3; wr_vpn = 20'h000DD; wr_ppn = 18'h00D0D; wr_vld = 1;
        fill_valid = 1; fill_vpn = 20'h000EE; fill_ppn = 18'h00E0E; step();
        look(20'h000DD, 12'h00E, 0, 1, 18'h00D0D, "R12 write applied");
        look(20'h000EE, 12'h000, 0, 0, '0, "R12 fill lost to write");
        look(20'h00044, 12'h000, 0, 0, '0, "R12 slot3 overwritten");

        // R3: prefetch hit returns translation
        look(20'h000BB, 12'h0F0, 1, 1, 18'h00B0B, "R3 prefetch hit");

        // R9: global invalidate, also beats a simultaneous fill (R12)
        @(negedge clk); inv_all = 1; fill_valid = 1; fill_vpn = 20'h000FF; fill_ppn = 18'h00F0F; step();
        look(20'h000BB, 12'h000, 0, 0, '0, "R9 flush slot2");
        look(20'h000DD, 12'h000, 1, 0, '0, "R9 flush slot3 prefetch");
        look(20'h000FF, 12'h000, 0, 0, '0, "R12 fill lost to flush");
        fill(20'h00012, 18'h00112);
        look(20'h00012, 12'h345, 0, 1, 18'h00112, "R4 fill after flush");

        repeat (2) @(posedge clk);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule